// File: doc/BRIEF.md
# Shared-DAC Successive Approximation Conversion Controller

This block sequences an 8-bit successive-approximation conversion that borrows the resistor-string DAC normally used for the analog output. The DAC tap is selected directly by the code on `dac_code`. Each code step raises the tap voltage by one LSB, which is the reference span divided by 256. A pulse on `conv_start` begins a conversion. The block first asserts `hold`, so that the output buffer keeps its voltage through its track-and-hold. It then fires the sampling switch for one cycle. After that it runs a binary search from the most significant bit down, using one external comparator whose output is high when the held input is at or above the current DAC tap.

When the search ends, the block formats the code. Single-ended conversions give straight binary. Differential conversions give two's complement, made by inverting the top bit of the search result. The formatted code goes into the result register in one step, and `conv_done` pulses in the same cycle. In that last busy cycle the DAC is handed back to the user's code. `hold` drops one cycle later. The comparator, the resistor string and the sampling switch are outside the block.

A conversion takes a fixed 18 clock cycles: one sampling cycle, eight trials of two cycles each, and one hand-back cycle. This is well inside the 90 µs limit for a conversion clock between 0.75 and 1.25 MHz.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `result` is 0x80 and stays 0x80 until the first conversion completes. `busy`, `hold`, `sample`, `conv_done` and `overrun` are low.
- R2: While idle, `dac_code` equals `user_code` and `hold` is low.
- R3: A `conv_start` seen while idle starts a conversion. `sample` is high for exactly one cycle, which is the first busy cycle. `hold` is high in every busy cycle.
- R4: The search is MSB first. Each bit trial takes two cycles with `dac_code` at the kept bits plus the trial bit. The first trial code is 0x80. The trial bit is kept when `cmp_in` is 1 in the trial's second cycle, so the second trial code is (kept bit 7) | 0x40.
- R5: With `diff_sel` = 0 at start, the result is straight binary: the highest code whose tap is at or below the held input, which is floor(input in LSB) limited to 0xFF.
- R6: With `diff_sel` = 1 at start, the result is the search code with bit 7 inverted. This is two's complement, so an input 128 LSB above ground gives 0x00, the bottom gives 0x80 (-128), and the top gives 0x7F (+127).
- R7: `busy` is high for exactly 18 cycles. `conv_done` is a single-cycle pulse in the last busy cycle. `result` takes the new value in that cycle and changes at no other time.
- R8: In the last busy cycle, `dac_code` equals the current `user_code` and `hold` is still high. In the next cycle `busy` and `hold` are low.
- R9: A `conv_start` while busy is ignored: the running conversion keeps its timing and its result. It also sets `overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Request to start a conversion |
| diff_sel | input | 1 | 1 = differential (two's complement), 0 = single-ended; latched at start |
| user_code | input | 8 | User's DAC register code for the analog output |
| cmp_in | input | 1 | Comparator: 1 when held input is at or above the DAC tap |
| dac_code | output | 8 | Tap select for the shared resistor-string DAC |
| hold | output | 1 | Track-and-hold command for the output buffer |
| sample | output | 1 | Sampling switch pulse for the input |
| busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle pulse when the result is written |
| result | output | 8 | Conversion result register |
| overrun | output | 1 | Sticky flag: a start arrived while busy |

## Verification
The hardest situations to reach are timing races around the shared DAC. One is a start request landing in the middle of a search. Another is the user code changing while the DAC is borrowed. The bench drives a second `conv_start` and a new `user_code` in the same cycle during the trials. It then checks that the cycle count and result are untouched, that the hand-back shows the new user code, and that the overrun flag survives a later clean conversion. A behavioural comparator holds the input it captured on `sample`, and the bench moves the live input right after that. A sample taken in the wrong cycle therefore produces a wrong code.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation controller.
// Assumes: one conversion sequencer per instance; states are local to it.
package sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_SETTLE,
        ST_DECIDE,
        ST_RESTORE
    } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
// Conversion sequencer: walks idle -> sample -> (settle, decide) x WIDTH ->
// restore, counting the bit under trial down from the MSB. It also keeps the
// sticky overrun flag for start requests that arrive while not idle.
// Assumes: conv_start is synchronous to clk.
module sar_seq
    import sar_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_start,
    output sar_state_e      state_o,
    output logic [IDXW-1:0] bit_idx_o,
    output logic            accept_o,
    output logic            finish_o,
    output logic            overrun_o
);
    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

    sar_state_e      state_q, state_d;
    logic [IDXW-1:0] idx_q;

    assign accept_o = (state_q == ST_IDLE) && conv_start;
    assign finish_o = (state_q == ST_DECIDE) && (idx_q == '0);

    // Next-state selection for the conversion sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (conv_start) state_d = ST_SAMPLE;
            ST_SAMPLE:  state_d = ST_SETTLE;
            ST_SETTLE:  state_d = ST_DECIDE;
            ST_DECIDE:  state_d = (idx_q == '0) ? ST_RESTORE : ST_SETTLE;
            ST_RESTORE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and trial-bit index, counting down after each decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= TOP_IDX;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SAMPLE)
                idx_q <= TOP_IDX;
            else if (state_q == ST_DECIDE && idx_q != '0)
                idx_q <= idx_q - 1'b1;
        end
    end

    // Sticky overrun: set by a start request seen outside idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun_o <= 1'b0;
        else if (conv_start && state_q != ST_IDLE)
            overrun_o <= 1'b1;
    end

    assign state_o   = state_q;
    assign bit_idx_o = idx_q;

    // R9: once set, overrun stays set until reset
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R9: a start while busy does not disturb the sequence
    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && state_q == ST_SETTLE) |=> (state_q == ST_DECIDE));
endmodule

// File: rtl/sar_reg.sv
// Successive-approximation register: holds the bits decided so far, forms
// the trial code (kept bits plus the bit under trial) and the value the
// register takes once the comparator is sampled.
// Assumes: cmp_in is high when the held input is at or above the DAC tap.
module sar_reg #(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             decide,
    input  logic [IDXW-1:0]  bit_idx,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] trial_code,
    output logic [WIDTH-1:0] kept_code
);
    logic [WIDTH-1:0] sar_q;

    // Per-bit trial and keep logic.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic on_trial;
        assign on_trial      = (bit_idx == IDXW'(g));
        assign trial_code[g] = sar_q[g] | on_trial;
        assign kept_code[g]  = on_trial ? cmp_in : sar_q[g];
    end

    // Clear at the start of a conversion, update after each decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sar_q <= '0;
        else if (accept)
            sar_q <= '0;
        else if (decide)
            sar_q <= kept_code;
    end

    // R4: a decision never touches bits above the one under trial
    p_upper_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && bit_idx != IDXW'(WIDTH - 1)) |=> (sar_q[WIDTH-1] == $past(sar_q[WIDTH-1])));
endmodule

// File: rtl/sar_result.sv
// Result formatting and storage: latches the number format at start, writes
// straight binary or two's complement into the result register when the last
// decision is made, and pulses the done strobe with it.
// Assumes: finish is high only in the final decision cycle.
module sar_result #(
    parameter int WIDTH = 8,
    localparam logic [WIDTH-1:0] RESET_CODE = {1'b1, {(WIDTH-1){1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             diff_sel,
    input  logic             finish,
    input  logic [WIDTH-1:0] kept_code,
    output logic [WIDTH-1:0] result_o,
    output logic             conv_done_o
);
    logic             diff_q;
    logic [WIDTH-1:0] formatted;

    // Two's complement is offset binary with the sign bit flipped.
    assign formatted = diff_q ? {~kept_code[WIDTH-1], kept_code[WIDTH-2:0]} : kept_code;

    // Capture the format selection when a conversion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            diff_q <= 1'b0;
        else if (accept)
            diff_q <= diff_sel;
    end

    // Result register and done strobe, written together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o    <= RESET_CODE;
            conv_done_o <= 1'b0;
        end else begin
            conv_done_o <= finish;
            if (finish)
                result_o <= formatted;
        end
    end

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_o |=> !conv_done_o);

    // R7: the result only changes together with done
    p_result_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done_o |-> $stable(result_o));
endmodule

// File: rtl/sar_ctrl.sv
// Top of the shared-DAC successive-approximation controller. Routes the DAC
// between the user code and the trial code, drives hold and sample, and
// connects sequencer, approximation register and result store.
// Assumes: external comparator, resistor string and sampling switch.
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH),
    localparam logic [WIDTH-1:0] FIRST_TRIAL = {1'b1, {(WIDTH-1){1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             diff_sel,
    input  logic [WIDTH-1:0] user_code,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             hold,
    output logic             sample,
    output logic             busy,
    output logic             conv_done,
    output logic [WIDTH-1:0] result,
    output logic             overrun
);
    sar_state_e       state;
    logic [IDXW-1:0]  bit_idx;
    logic             accept;
    logic             finish;
    logic             in_trial;
    logic [WIDTH-1:0] trial_code;
    logic [WIDTH-1:0] kept_code;

    sar_seq #(.WIDTH(WIDTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .state_o    (state),
        .bit_idx_o  (bit_idx),
        .accept_o   (accept),
        .finish_o   (finish),
        .overrun_o  (overrun)
    );

    sar_reg #(.WIDTH(WIDTH)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .decide     (state == ST_DECIDE),
        .bit_idx    (bit_idx),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .kept_code  (kept_code)
    );

    sar_result #(.WIDTH(WIDTH)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .diff_sel    (diff_sel),
        .finish      (finish),
        .kept_code   (kept_code),
        .result_o    (result),
        .conv_done_o (conv_done)
    );

    // DAC ownership and analog control outputs.
    always_comb begin
        in_trial = (state == ST_SETTLE) || (state == ST_DECIDE);
        dac_code = in_trial ? trial_code : user_code;
        busy     = (state != ST_IDLE);
        hold     = busy;
        sample   = (state == ST_SAMPLE);
    end

    // R3: sampling lasts exactly one cycle
    p_sample_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

    // R4: the cycle after sampling presents the MSB trial
    p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sample) |-> (dac_code == FIRST_TRIAL));

    // R8: hand-back shows the user code while hold is still asserted
    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (dac_code == user_code && hold));

    // R8: hold releases the cycle after done
    p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !hold);
endmodule

// File: tb/sar_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       conv_start;
    logic       diff_sel;
    logic [7:0] user_code;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic       hold, sample, busy, conv_done, overrun;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;

    // Analog input in quarter-LSB units, and the value held by the sampler.
    int vin_q = 0;
    int held_q = 0;

    always #2.5 clk = ~clk;

    // Behavioural sample switch and comparator.
    always @(posedge clk) if (sample) held_q <= vin_q;
    assign cmp_in = (held_q >= int'(dac_code) * 4);

    sar_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .diff_sel(diff_sel),
        .user_code(user_code), .cmp_in(cmp_in), .dac_code(dac_code), .hold(hold),
        .sample(sample), .busy(busy), .conv_done(conv_done), .result(result),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Runs one conversion and checks its timing, DAC use and result.
    task automatic run_conv(input int aq, input bit diff, input logic [7:0] exp,
                            input string req, input bit inject);
        int idx = 1;
        int s_cnt = 0, s_idx = 0, d_cnt = 0, d_idx = 0;
        int hold_bad = 0;
        logic [7:0] dac2 = 0, dac4 = 0, d_dac = 0, d_user = 0, d_res = 0, pre_res, res17 = 0;
        int sar_exp = (aq / 4 > 255) ? 255 : aq / 4;
        vin_q    = aq;
        diff_sel = diff;
        @(negedge clk);
        pre_res    = result;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        while (busy && idx < 40) begin
            if (sample) begin s_cnt++; s_idx = idx; end
            if (!hold) hold_bad++;
            if (idx == 2) begin
                dac2  = dac_code;
                vin_q = (aq + 300) % 1024;
            end
            if (idx == 4) dac4 = dac_code;
            if (idx == 17) res17 = result;
            if (conv_done) begin
                d_cnt++; d_idx = idx; d_dac = dac_code; d_user = user_code; d_res = result;
            end
            if (inject && idx == 5) begin
                conv_start = 1'b1;
                user_code  = 8'h99;
            end else begin
                conv_start = 1'b0;
            end
            @(negedge clk);
            idx++;
        end
        conv_start = 1'b0;
        chk(idx - 1 == 18, "R7", "busy cycles", idx - 1, 18);
        chk(d_cnt == 1 && d_idx == 18, "R7", "done pulse cycle", d_idx, 18);
        chk(res17 == pre_res, "R7", "result before done", res17, pre_res);
        chk(s_cnt == 1 && s_idx == 1, "R3", "sample cycle", s_idx, 1);
        chk(hold_bad == 0, "R3", "hold low while busy", hold_bad, 0);
        chk(dac2 == 8'h80, "R4", "first trial code", dac2, 8'h80);
        chk(dac4 == ((sar_exp[7:0] & 8'h80) | 8'h40), "R4", "second trial code",
            dac4, (sar_exp[7:0] & 8'h80) | 8'h40);
        chk(d_dac == d_user, "R8", "dac at hand-back", d_dac, d_user);
        chk(!hold && !busy, "R8", "hold after done", hold, 0);
        chk(d_res == exp && result == exp, req, "conversion result", d_res, exp);
    endtask

    task automatic test_reset();
        chk(result == 8'h80, "R1", "reset result", result, 8'h80);
        chk({busy, hold, sample, conv_done, overrun} == 5'b0, "R1", "reset flags",
            {busy, hold, sample, conv_done, overrun}, 0);
        chk(dac_code == user_code, "R1", "reset dac", dac_code, user_code);
    endtask

    task automatic test_idle();
        user_code = 8'h3C;
        @(negedge clk);
        chk(dac_code == 8'h3C && !hold, "R2", "idle dac follows user", dac_code, 8'h3C);
        user_code = 8'hC3;
        @(negedge clk);
        chk(dac_code == 8'hC3 && !hold, "R2", "idle dac follows user", dac_code, 8'hC3);
        chk(result == 8'h80, "R1", "result before first conversion", result, 8'h80);
    endtask

    task automatic test_single();
        run_conv(0,            1'b0, 8'h00, "R5", 1'b0);
        run_conv(1023,         1'b0, 8'hFF, "R5", 1'b0);
        run_conv(4*8'hA5 + 2,  1'b0, 8'hA5, "R5", 1'b0);
        run_conv(4*128 - 1,    1'b0, 8'h7F, "R5", 1'b0);
    endtask

    task automatic test_diff();
        run_conv(0,          1'b1, 8'h80, "R6", 1'b0);
        run_conv(255*4,      1'b1, 8'h7F, "R6", 1'b0);
        run_conv(512,        1'b1, 8'h00, "R6", 1'b0);
        run_conv(127*4 + 3,  1'b1, 8'hFF, "R6", 1'b0);
    endtask

    task automatic test_overrun();
        chk(overrun == 1'b0, "R9", "overrun before", overrun, 0);
        user_code = 8'h11;
        run_conv(4*8'h5A + 1, 1'b0, 8'h5A, "R9", 1'b1);
        chk(overrun == 1'b1, "R9", "overrun set", overrun, 1);
        chk(dac_code == 8'h99, "R9", "new user code in idle", dac_code, 8'h99);
        run_conv(4*8'h21, 1'b0, 8'h21, "R9", 1'b0);
        chk(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        conv_start = 1'b0;
        diff_sel   = 1'b0;
        user_code  = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle();
        test_single();
        test_diff();
        test_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule